// File: doc/BRIEF.md
# ADC Result Offset Correction and Clip Encoder

This block is the digital output-conditioning stage behind a successive-approximation converter. Each completed conversion arrives as a signed raw value, together with a one-cycle done pulse. The block adds a signed correction held in a register to that value. It then encodes the sum into a 15-bit result word: a 14-bit code plus an overrange flag in the top bit. Software writes the correction register through a simple strobe-and-chip-select bus.

Two output encodings are available. With clipping enabled, any sum outside the nominal span saturates to the nearest end of the 14-bit code. With clipping disabled, the overrange flag is raised instead. The low bits then carry the signed distance past the violated bound, so values somewhat outside the nominal span can still be resolved.

A latch-mode input selects when a finished result reaches the output register. In one mode the result lands as soon as the conversion ends. In the other mode it is held internally and appears at the next conversion start. All inputs are sampled on the rising clock edge. The edges of the write strobe and of the active-low start signal are detected by comparing each input against its value one clock earlier.

Top module: `adc_result_cond`

## Requirements
- R1: While `rst_n` is low, `result`, `busy` and the correction register are all zero, and no result is pending. A reset during a conversion aborts it, so a later `conv_done` pulse leaves `result` at zero.
- R2: The correction register takes the value of `bus_d` (14-bit two's complement) at the clock where `wr_strobe` is first seen low after being high, provided `cs_n` is low in that clock. A falling strobe with `cs_n` high leaves the register unchanged.
- R3: The sum of raw value and correction is formed one bit wider than `raw_val`, so it never wraps. Raw 32767 plus correction 8191 counts as above full scale, not as negative.
- R4: With `clip_en` high, a sum above 16383 yields `result` = 0x3FFF and a sum below 0 yields 0x0000. The overrange bit (bit 14) is never set in this mode.
- R5: A sum in 0..16383 yields `result` = {0, sum} in either clip setting.
- R6: With `clip_en` low and sum above 16383, `result` = {1, sum − 16384}, with that excess capped at 8191.
- R7: With `clip_en` low and sum below 0, `result` = {1, low 14 bits of the sum}, with the sum floored at −8192 before encoding.
- R8: With `mode_sel` = 1 (latch at end), `result` takes the encoded value one clock after an accepted `conv_done`.
- R9: With `mode_sel` = 0 (latch at start), an accepted `conv_done` leaves `result` unchanged and stores the encoded value. That value moves to `result` one clock after the next accepted start edge. The correction applied is the one in force at `conv_done`.
- R10: A falling edge of `convst_n` while idle sets `busy` on the next clock. `busy` clears one clock after `conv_done`. A start edge while busy is ignored, and `conv_done` while idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select for correction writes |
| wr_strobe | input | 1 | Write strobe; its falling edge loads the correction |
| bus_d | input | 14 | Correction value, two's complement |
| clip_en | input | 1 | 1 = saturate, 0 = overrange encoding |
| mode_sel | input | 1 | 1 = latch at end of conversion, 0 = latch at next start |
| convst_n | input | 1 | Active-low conversion start; falling edge starts |
| conv_done | input | 1 | One-cycle end-of-conversion pulse |
| raw_val | input | 16 | Raw signed conversion value, valid with `conv_done` |
| busy | output | 1 | Conversion in progress |
| result | output | 15 | Overrange bit 14, code bits 13:0 |

## Verification
The hardest states to reach are the saturated overrange codes. They need a raw value near the 16-bit limit combined with a large correction of the same sign, which is exactly where a narrow adder would wrap. The stimulus first writes corrections of ±8191/−8192 and then issues conversions at raw 32767 and −32768 under both clip settings. The held result in latch-at-start mode is reached by finishing a conversion and then issuing a further start. Reset is pulsed between a start and its done pulse.

// File: rtl/adc_rc_pkg.sv
package adc_rc_pkg;
  typedef enum logic {
    LATCH_ON_START = 1'b0,
    LATCH_ON_DONE  = 1'b1
  } latch_mode_e;

  typedef enum logic [1:0] {
    ZONE_IN   = 2'd0,
    ZONE_HIGH = 2'd1,
    ZONE_LOW  = 2'd2
  } zone_e;
endpackage

// File: rtl/adc_rc_offset_reg.sv
module adc_rc_offset_reg #(
  parameter int CODE_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_strobe,
  input  logic [CODE_W-1:0] bus_d,
  output logic [CODE_W-1:0] ofs_q,
  output logic              load_o
);
  logic wr_q;

  // falling edge of the strobe, qualified by chip select
  assign load_o = wr_q & ~wr_strobe & ~cs_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= 1'b0;
      ofs_q <= '0;
    end else begin
      wr_q <= wr_strobe;
      if (load_o) ofs_q <= bus_d;
    end
  end

  p_ofs_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> ofs_q == $past(bus_d));
  p_ofs_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_o |=> $stable(ofs_q));
endmodule

// File: rtl/adc_rc_condition.sv
module adc_rc_condition
  import adc_rc_pkg::*;
#(
  parameter int CODE_W = 14,
  parameter int RAW_W  = 16
) (
  input  logic signed [RAW_W-1:0]  raw_val,
  input  logic        [CODE_W-1:0] ofs,
  input  logic                     clip_en,
  output logic        [CODE_W:0]   word,
  output zone_e                    zone
);
  localparam int SUM_W = RAW_W + 1;
  localparam int OUT_W = CODE_W + 1;
  localparam logic signed [SUM_W-1:0] FS_TOP = SUM_W'((1 << CODE_W) - 1);
  localparam logic signed [SUM_W-1:0] SPAN   = SUM_W'(1 << CODE_W);
  localparam logic signed [SUM_W-1:0] EX_MAX = SUM_W'((1 << (CODE_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] EX_MIN = -SUM_W'(1 << (CODE_W - 1));

  logic signed [SUM_W-1:0] sum;

  function automatic zone_e classify(input logic signed [SUM_W-1:0] s);
    if (s < 0)           return ZONE_LOW;
    else if (s > FS_TOP) return ZONE_HIGH;
    else                 return ZONE_IN;
  endfunction

  function automatic logic [OUT_W-1:0] encode(input logic signed [SUM_W-1:0] s,
                                              input zone_e z, input logic clip);
    logic signed [SUM_W-1:0] ex;
    logic [OUT_W-1:0] w;
    ex = '0;
    w  = '0;
    unique case (z)
      ZONE_IN: w = {1'b0, s[CODE_W-1:0]};
      ZONE_HIGH: begin
        if (clip) w = {1'b0, {CODE_W{1'b1}}};
        else begin
          ex = s - SPAN;
          if (ex > EX_MAX) ex = EX_MAX;
          w = {1'b1, ex[CODE_W-1:0]};
        end
      end
      default: begin
        if (clip) w = '0;
        else begin
          ex = (s < EX_MIN) ? EX_MIN : s;
          w = {1'b1, ex[CODE_W-1:0]};
        end
      end
    endcase
    return w;
  endfunction

  always_comb begin
    sum  = SUM_W'(raw_val) + SUM_W'($signed(ofs));
    zone = classify(sum);
    word = encode(sum, zone, clip_en);
  end

  always_comb begin
    if (clip_en) p_clip_no_ovr_r4: assert (!word[OUT_W-1]);
    if (zone == ZONE_IN) p_inrange_flag_r5: assert (!word[OUT_W-1]);
  end
endmodule

// File: rtl/adc_rc_conv_ctrl.sv
module adc_rc_conv_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic convst_n,
  input  logic conv_done,
  output logic busy,
  output logic start_acc,
  output logic done_acc
);
  logic cv_q;

  assign start_acc = cv_q & ~convst_n & ~busy;
  assign done_acc  = conv_done & busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cv_q <= 1'b1;
      busy <= 1'b0;
    end else begin
      cv_q <= convst_n;
      if (start_acc)     busy <= 1'b1;
      else if (done_acc) busy <= 1'b0;
    end
  end

  p_busy_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> busy);
  p_busy_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_acc |=> !busy);
  p_busy_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_acc) |=> !busy);
endmodule

// File: rtl/adc_rc_out_latch.sv
module adc_rc_out_latch
  import adc_rc_pkg::*;
#(
  parameter int OUT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  latch_mode_e      mode,
  input  logic             start_acc,
  input  logic             done_acc,
  input  logic [OUT_W-1:0] word,
  output logic [OUT_W-1:0] out_q
);
  logic [OUT_W-1:0] pend_q;
  logic             pend_vld;
  logic             load_end, load_start;

  assign load_end   = done_acc & (mode == LATCH_ON_DONE);
  assign load_start = start_acc & (mode == LATCH_ON_START) & pend_vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q    <= '0;
      pend_q   <= '0;
      pend_vld <= 1'b0;
    end else begin
      if (load_end) out_q <= word;
      if (load_start) begin
        out_q    <= pend_q;
        pend_vld <= 1'b0;
      end
      if (done_acc && mode == LATCH_ON_START) begin
        pend_q   <= word;
        pend_vld <= 1'b1;
      end
    end
  end

  p_end_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_end |=> out_q == $past(word));
  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_end || load_start) |=> $stable(out_q));
  p_done_no_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_acc && mode == LATCH_ON_START) |=> $stable(out_q));
endmodule

// File: rtl/adc_result_cond.sv
module adc_result_cond
  import adc_rc_pkg::*;
#(
  parameter int CODE_W = 14,
  parameter int RAW_W  = 16,
  localparam int OUT_W = CODE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_strobe,
  input  logic [CODE_W-1:0] bus_d,
  input  logic              clip_en,
  input  logic              mode_sel,
  input  logic              convst_n,
  input  logic              conv_done,
  input  logic [RAW_W-1:0]  raw_val,
  output logic              busy,
  output logic [OUT_W-1:0]  result
);
  logic [CODE_W-1:0] ofs_q;
  logic              ofs_load;
  logic [OUT_W-1:0]  cond_word;
  zone_e             cond_zone;
  logic              start_acc, done_acc;
  latch_mode_e       mode;

  assign mode = latch_mode_e'(mode_sel);

  adc_rc_offset_reg #(.CODE_W(CODE_W)) u_ofs (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_strobe(wr_strobe),
    .bus_d(bus_d), .ofs_q(ofs_q), .load_o(ofs_load)
  );

  adc_rc_condition #(.CODE_W(CODE_W), .RAW_W(RAW_W)) u_cond (
    .raw_val($signed(raw_val)), .ofs(ofs_q), .clip_en(clip_en),
    .word(cond_word), .zone(cond_zone)
  );

  adc_rc_conv_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .convst_n(convst_n), .conv_done(conv_done),
    .busy(busy), .start_acc(start_acc), .done_acc(done_acc)
  );

  adc_rc_out_latch #(.OUT_W(OUT_W)) u_out (
    .clk(clk), .rst_n(rst_n), .mode(mode), .start_acc(start_acc),
    .done_acc(done_acc), .word(cond_word), .out_q(result)
  );

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (result == '0 && !busy));
  p_clip_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_acc && clip_en && mode == LATCH_ON_DONE) |=> !result[OUT_W-1]);
endmodule

// File: tb/adc_result_cond_tb.sv
module adc_result_cond_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, wr_strobe = 1'b0;
  logic [13:0] bus_d = '0;
  logic        clip_en = 1'b0, mode_sel = 1'b1;
  logic        convst_n = 1'b1, conv_done = 1'b0;
  logic [15:0] raw_val = '0;
  logic        busy;
  logic [14:0] result;

  int n_chk = 0, n_bad = 0, cyc = 0;
  string cur_req = "R1";

  adc_result_cond u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_strobe(wr_strobe), .bus_d(bus_d),
    .clip_en(clip_en), .mode_sel(mode_sel), .convst_n(convst_n),
    .conv_done(conv_done), .raw_val(raw_val), .busy(busy), .result(result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // expected encoding, stated from the requirements
  function automatic int exp_word(int raw, int ofs, bit clip);
    int s, e;
    s = raw + ofs;
    if (s >= 0 && s < 16384) return s;
    if (clip) return (s > 0) ? 16383 : 0;
    if (s > 0) begin
      e = s - 16384;
      if (e > 8191) e = 8191;
      return 16384 + e;
    end
    e = (s < -8192) ? -8192 : s;
    return 16384 + (e & 16383);
  endfunction

  // behavioural reference model
  int m_ofs, m_out, m_pend;
  bit m_pvld, m_busy, m_wr, m_cv;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ofs = 0; m_out = 0; m_pend = 0; m_pvld = 0; m_busy = 0; m_wr = 0; m_cv = 1;
    end else begin
      int old_ofs;
      old_ofs = m_ofs;
      if (m_wr && !wr_strobe && !cs_n) m_ofs = int'($signed(bus_d));
      if (!m_busy && m_cv && !convst_n) begin
        m_busy = 1;
        if (!mode_sel && m_pvld) begin m_out = m_pend; m_pvld = 0; end
      end else if (m_busy && conv_done) begin
        m_busy = 0;
        if (mode_sel) m_out = exp_word(int'($signed(raw_val)), old_ofs, clip_en);
        else begin
          m_pend = exp_word(int'($signed(raw_val)), old_ofs, clip_en);
          m_pvld = 1;
        end
      end
      m_wr = wr_strobe;
      m_cv = convst_n;
    end
  end

  task automatic chk(int got, int exp, string req);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at cycle %0d", req, got, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cyc++;
    chk(int'(result), m_out, cur_req);
    chk(int'(busy), int'(m_busy), "R10");
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic write_ofs(int v, bit cs);
    @(negedge clk); bus_d = 14'(v); cs_n = ~cs; wr_strobe = 1'b1;
    @(negedge clk); wr_strobe = 1'b0;
    @(negedge clk); cs_n = 1'b1;
  endtask

  task automatic start_pulse();
    @(negedge clk); convst_n = 1'b0;
    @(negedge clk); convst_n = 1'b1;
  endtask

  task automatic done_pulse(int raw);
    @(negedge clk); raw_val = 16'(raw); conv_done = 1'b1;
    @(negedge clk); conv_done = 1'b0;
  endtask

  task automatic conv(int raw);
    start_pulse();
    repeat (2) @(negedge clk);
    done_pulse(raw);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(int'(result), 0, "R1 reset result");
    chk(int'(busy), 0, "R1 reset busy");
    rst_n = 1'b1;

    cur_req = "R5"; mode_sel = 1'b1;
    conv(1000);           chk(int'(result), 1000, "R5 R8 in range");
    cur_req = "R2";
    write_ofs(-500, 1);   conv(1000); chk(int'(result), 500, "R2 offset applied");
    write_ofs(300, 0);    conv(1000); chk(int'(result), 500, "R2 cs high ignored");
    cur_req = "R6";
    conv(16500);          chk(int'(result), 16000, "R5 near top");
    conv(17000);          chk(int'(result), 16500, "R6 overrange high");
    cur_req = "R7";
    conv(200);            chk(int'(result), 32468, "R7 overrange low");
    cur_req = "R3";
    write_ofs(8191, 1);   conv(32767); chk(int'(result), 24575, "R3 R6 no wrap sat");
    write_ofs(-8192, 1);  conv(-32768); chk(int'(result), 24576, "R7 floor");
    cur_req = "R4"; clip_en = 1'b1;
    conv(-32768);         chk(int'(result), 0, "R4 clip low");
    write_ofs(8191, 1);   conv(32767); chk(int'(result), 16383, "R4 clip high");
    conv(100);            chk(int'(result), 8291, "R4 R5 in range with clip");

    cur_req = "R9"; clip_en = 1'b0; mode_sel = 1'b0;
    conv(500);            chk(int'(result), 8291, "R9 held at done");
    write_ofs(0, 1);
    start_pulse();        chk(int'(result), 8691, "R9 moved at start");
    repeat (2) @(negedge clk);
    done_pulse(42);       chk(int'(result), 8691, "R9 new result held");

    cur_req = "R10"; mode_sel = 1'b1;
    done_pulse(7);        chk(int'(busy), 0, "R10 done idle ignored");
                          chk(int'(result), 8691, "R10 idle done no load");
    start_pulse();        chk(int'(busy), 1, "R10 busy set");
    start_pulse();        done_pulse(77); chk(int'(result), 77, "R10 R8 start while busy");
                          chk(int'(busy), 0, "R10 busy clear");

    cur_req = "R1";
    start_pulse();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk(int'(result), 0, "R1 reset clears");
    done_pulse(999);      chk(int'(result), 0, "R1 aborted conversion");
                          chk(int'(busy), 0, "R1 aborted busy");
    write_ofs(0, 0); conv(5); chk(int'(result), 5, "R1 offset cleared");

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule